// File: doc/BRIEF.md
# Two-Player Tic-Tac-Toe Game Controller

This block referees a two-player game of tic-tac-toe on a 3x3 grid. Each of the nine cells has its own key input, which carries a clean, debounced pulse that is one clock cycle wide. The block keeps the board and whose turn it is. It accepts or rejects each press and decides when the game is over. Its outputs are nine cell LEDs, two turn LEDs and a 3-bit status code. An external display driver turns that code into text.

Cells are numbered 0 to 8 in row-major order, so cell 3r+c sits at row r, column c, and key bit i selects cell i. Each cell holds a 2-bit mark: 00 for empty, 01 for player 1 and 10 for player 2. Player 1's marks light their LED on every cycle. Player 2's marks light it at a dim duty cycle, DIM_ON out of every DIM_PERIOD cycles. After a win, the three cells of the winning line blink: each is dark during alternate spans of BLINK_HALF cycles, and all other lit cells stay steady.

Top module: `ttt_game`

## Requirements
- R1: After reset the board is empty and every cell LED is dark. The status is 0 (playing), and turn_led_o is 2'b01, meaning player 1 moves first (bit 0 is player 1, bit 1 is player 2).
- R2: While a game is in progress, exactly one turn LED is lit, and each accepted move passes the turn to the other player.
- R3: An accepted press on cell i lights LED i. A player-1 cell is lit on every cycle. A player-2 cell is lit on DIM_ON cycles of every DIM_PERIOD cycles. An empty cell is always dark.
- R4: A press on an occupied cell leaves the board unchanged and sets the status to 1 (occupied). The same player keeps the turn.
- R5: The occupied status returns to 0 on the next accepted move.
- R6: When several keys pulse in the same cycle, only the lowest-numbered key is acted on. The others are dropped.
- R7: When a player holds all three cells of any row, column or diagonal, the status becomes 2 if player 1 won or 3 if player 2 won. The status appears two clock edges after the key is sampled.
- R8: After a win, each LED of the winning line is dark during alternate spans of BLINK_HALF cycles. Every other lit cell keeps the brightness set by R3.
- R9: When all nine cells are filled and no line is complete, the status becomes 4 (draw).
- R10: If a ninth move completes a line, the game reports a win, not a draw.
- R11: After a win or a draw, both turn LEDs are dark. Key presses change neither the board nor the status until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| key_i | input | 9 | One-cycle press pulse per cell, bit i is cell i |
| cell_led_o | output | 9 | Cell LEDs, bit i is cell i |
| turn_led_o | output | 2 | Next-player LEDs, bit 0 is player 1, bit 1 is player 2 |
| status_o | output | 3 | 0 playing, 1 occupied, 2 player 1 wins, 3 player 2 wins, 4 draw |

## Verification
The bench builds the block with BLINK_HALF=8, DIM_PERIOD=4 and DIM_ON=1. These values make a 16-cycle observation window a whole multiple of both the blink period and the dim period. Counting how many cycles each LED is on in that window then gives a fixed value for every state, whatever the counter phase: 16 for a steady player-1 cell, 4 for a dim player-2 cell, half of that for a blinking cell, and 0 for an empty one. With these short periods the bench can play a full game for every one of the 8 lines, won by each player. It also plays a plain draw, a draw-shaped game closed by a winning ninth move, simultaneous key presses, and presses on occupied cells.

// File: rtl/ttt_pkg.sv
package ttt_pkg;

    localparam int SIDE   = 3;
    localparam int NCELLS = SIDE * SIDE;
    localparam int NLINES = 2 * SIDE + 2;

    typedef enum logic [1:0] {
        MARK_NONE = 2'b00,
        MARK_P1   = 2'b01,
        MARK_P2   = 2'b10
    } mark_e;

    typedef logic [NCELLS-1:0][1:0] board_t;

    typedef enum logic [2:0] {
        ST_PLAYING  = 3'd0,
        ST_OCCUPIED = 3'd1,
        ST_P1_WIN   = 3'd2,
        ST_P2_WIN   = 3'd3,
        ST_DRAW     = 3'd4
    } status_e;

    typedef enum logic [1:0] {
        PH_PLAY  = 2'd0,
        PH_CHECK = 2'd1,
        PH_WON   = 2'd2,
        PH_DRAWN = 2'd3
    } phase_e;

    // Cell index of the k-th cell on line l: rows, then columns, then diagonals.
    function automatic int line_cell(int l, int k);
        if (l < SIDE)           return SIDE * l + k;
        else if (l < 2 * SIDE)  return (l - SIDE) + SIDE * k;
        else if (l == 2 * SIDE) return (SIDE + 1) * k;
        else                    return (SIDE - 1) + (SIDE - 1) * k;
    endfunction

endpackage

// File: rtl/ttt_key_pick.sv
module ttt_key_pick #(
    parameter  int N  = 9,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  key_i,
    output logic          valid_o,
    output logic [IW-1:0] idx_o
);

    // Lowest-numbered pressed key wins.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (key_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/ttt_line_eval.sv
module ttt_line_eval
    import ttt_pkg::*;
(
    input  board_t            board_i,
    input  logic [1:0]        mark_i,
    output logic              hit_o,
    output logic [NCELLS-1:0] mask_o
);

    logic [NLINES-1:0]             hit;
    logic [NLINES-1:0][NCELLS-1:0] lmask;

    for (genvar l = 0; l < NLINES; l++) begin : g_line
        localparam int CA = line_cell(l, 0);
        localparam int CB = line_cell(l, 1);
        localparam int CC = line_cell(l, 2);

        assign hit[l]   = (mark_i != MARK_NONE) &&
                          (board_i[CA] == mark_i) &&
                          (board_i[CB] == mark_i) &&
                          (board_i[CC] == mark_i);
        assign lmask[l] = (NCELLS'(1) << CA) | (NCELLS'(1) << CB) |
                          (NCELLS'(1) << CC);
    end

    // The lowest-numbered completed line is reported.
    always_comb begin
        hit_o  = 1'b0;
        mask_o = '0;
        for (int l = NLINES - 1; l >= 0; l--) begin
            if (hit[l]) begin
                hit_o  = 1'b1;
                mask_o = lmask[l];
            end
        end
    end

endmodule

// File: rtl/ttt_led_drive.sv
module ttt_led_drive
    import ttt_pkg::*;
#(
    parameter  int BLINK_HALF = 31_250_000,
    parameter  int DIM_PERIOD = 8,
    parameter  int DIM_ON     = 1,
    localparam int BW         = $clog2(BLINK_HALF),
    localparam int DW         = $clog2(DIM_PERIOD)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  board_t            board_i,
    input  logic              blink_en_i,
    input  logic [NCELLS-1:0] blink_mask_i,
    output logic [NCELLS-1:0] led_o
);

    typedef struct packed {
        logic [BW-1:0] blink_cnt;
        logic          blink_on;
        logic [DW-1:0] dim_cnt;
    } ctr_t;

    ctr_t d, q;
    logic dim_lit;

    always_comb begin
        d = q;
        if (q.blink_cnt == BW'(BLINK_HALF - 1)) begin
            d.blink_cnt = '0;
            d.blink_on  = ~q.blink_on;
        end else begin
            d.blink_cnt = q.blink_cnt + BW'(1);
        end
        if (q.dim_cnt == DW'(DIM_PERIOD - 1)) begin
            d.dim_cnt = '0;
        end else begin
            d.dim_cnt = q.dim_cnt + DW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{blink_cnt: '0, blink_on: 1'b1, dim_cnt: '0};
        end else begin
            q <= d;
        end
    end

    assign dim_lit = ({1'b0, q.dim_cnt} < (DW + 1)'(DIM_ON));

    always_comb begin
        for (int i = 0; i < NCELLS; i++) begin
            case (board_i[i])
                MARK_P1: led_o[i] = 1'b1;
                MARK_P2: led_o[i] = dim_lit;
                default: led_o[i] = 1'b0;
            endcase
            if (blink_en_i && blink_mask_i[i] && !q.blink_on) begin
                led_o[i] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ttt_game.sv
module ttt_game
    import ttt_pkg::*;
#(
    parameter int CLK_HZ     = 125_000_000,
    parameter int BLINK_HZ   = 2,
    parameter int BLINK_HALF = CLK_HZ / (2 * BLINK_HZ),
    parameter int DIM_PERIOD = 8,
    parameter int DIM_ON     = 1
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic [8:0]  key_i,
    output logic [8:0]  cell_led_o,
    output logic [1:0]  turn_led_o,
    output logic [2:0]  status_o
);

    localparam int IW = $clog2(NCELLS);

    typedef struct packed {
        board_t            board;
        phase_e            phase;
        logic              turn;
        logic [1:0]        last;
        status_e           status;
        logic [NCELLS-1:0] win_mask;
    } game_t;

    game_t d, q;

    logic              key_valid;
    logic [IW-1:0]     key_idx;
    logic              line_hit;
    logic [NCELLS-1:0] line_mask;
    logic              board_full;

    // Signals exposed for the bound checker.
    board_t            board_q;
    logic [1:0]        phase_q;
    logic [NCELLS-1:0] win_mask_q;

    ttt_key_pick #(.N(NCELLS)) u_pick (
        .key_i   (key_i),
        .valid_o (key_valid),
        .idx_o   (key_idx)
    );

    ttt_line_eval u_lines (
        .board_i (q.board),
        .mark_i  (q.last),
        .hit_o   (line_hit),
        .mask_o  (line_mask)
    );

    always_comb begin
        board_full = 1'b1;
        for (int i = 0; i < NCELLS; i++) begin
            if (q.board[i] == MARK_NONE) board_full = 1'b0;
        end
    end

    always_comb begin
        d = q;
        case (q.phase)
            PH_PLAY: begin
                if (key_valid) begin
                    if (q.board[key_idx] != MARK_NONE) begin
                        d.status = ST_OCCUPIED;
                    end else begin
                        d.board[key_idx] = q.turn ? MARK_P2 : MARK_P1;
                        d.last           = q.turn ? MARK_P2 : MARK_P1;
                        d.turn           = ~q.turn;
                        d.status         = ST_PLAYING;
                        d.phase          = PH_CHECK;
                    end
                end
            end
            PH_CHECK: begin
                if (line_hit) begin
                    d.phase    = PH_WON;
                    d.status   = (q.last == MARK_P1) ? ST_P1_WIN : ST_P2_WIN;
                    d.win_mask = line_mask;
                end else if (board_full) begin
                    d.phase  = PH_DRAWN;
                    d.status = ST_DRAW;
                end else begin
                    d.phase = PH_PLAY;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '{board: '0, phase: PH_PLAY, turn: 1'b0, last: MARK_NONE,
                   status: ST_PLAYING, win_mask: '0};
        end else begin
            q <= d;
        end
    end

    ttt_led_drive #(
        .BLINK_HALF (BLINK_HALF),
        .DIM_PERIOD (DIM_PERIOD),
        .DIM_ON     (DIM_ON)
    ) u_leds (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .board_i      (q.board),
        .blink_en_i   (q.phase == PH_WON),
        .blink_mask_i (q.win_mask),
        .led_o        (cell_led_o)
    );

    assign turn_led_o = (q.phase == PH_PLAY || q.phase == PH_CHECK) ?
                        {q.turn, ~q.turn} : 2'b00;
    assign status_o   = q.status;

    assign board_q    = q.board;
    assign phase_q    = q.phase;
    assign win_mask_q = q.win_mask;

endmodule

// File: rtl/ttt_game_chk.sv
module ttt_game_chk
    import ttt_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [8:0]        key_i,
    input logic [8:0]        cell_led_o,
    input logic [1:0]        turn_led_o,
    input logic [2:0]        status_o,
    input board_t            board_q,
    input logic [1:0]        phase_q,
    input logic [NCELLS-1:0] win_mask_q
);

    logic [NCELLS-1:0] occ;
    logic [NCELLS-1:0] low_key;
    logic              game_over;

    always_comb begin
        for (int i = 0; i < NCELLS; i++) occ[i] = (board_q[i] != MARK_NONE);
    end

    assign low_key   = key_i & (~key_i + 9'd1);
    assign game_over = (status_o == ST_P1_WIN) || (status_o == ST_P2_WIN) ||
                       (status_o == ST_DRAW);

    // R2
    turn_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !game_over |-> $countones(turn_led_o) == 1);

    // R3
    empty_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cell_led_o & ~occ) == '0);

    // R4
    occupied_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_q == PH_PLAY && (low_key & occ) != '0)
        |=> $stable(board_q) && status_o == ST_OCCUPIED && $stable(turn_led_o));

    // R11
    frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        game_over |=> $stable(board_q) && $stable(status_o) && turn_led_o == 2'b00);

    // R7
    win_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o == ST_P1_WIN || status_o == ST_P2_WIN)
        |-> $countones(win_mask_q) == 3);

endmodule

bind ttt_game ttt_game_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_i      (key_i),
    .cell_led_o (cell_led_o),
    .turn_led_o (turn_led_o),
    .status_o   (status_o),
    .board_q    (board_q),
    .phase_q    (phase_q),
    .win_mask_q (win_mask_q)
);

// File: tb/tb_ttt_game.sv
module tb_ttt_game;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] key = '0;
    logic [8:0] cell_led;
    logic [1:0] turn_led;
    logic [2:0] status;

    int nchecks = 0;
    int nerr = 0;
    bit done = 1'b0;
    int cnt [9];
    int mv [9];

    always #4 clk = ~clk;

    ttt_game #(.BLINK_HALF(8), .DIM_PERIOD(4), .DIM_ON(1)) dut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .key_i      (key),
        .cell_led_o (cell_led),
        .turn_led_o (turn_led),
        .status_o   (status)
    );

    task automatic chk(string req, int act, int exp);
        nchecks++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        key = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic press(logic [8:0] m);
        @(negedge clk);
        key = m;
        @(negedge clk);
        key = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic window();
        for (int i = 0; i < 9; i++) cnt[i] = 0;
        for (int c = 0; c < 16; c++) begin
            @(negedge clk);
            for (int i = 0; i < 9; i++) cnt[i] += int'(cell_led[i]);
        end
    endtask

    task automatic check_leds(string req, logic [8:0] m1, logic [8:0] m2, logic [8:0] bl);
        window();
        for (int i = 0; i < 9; i++) begin
            int e;
            e = m1[i] ? 16 : (m2[i] ? 4 : 0);
            if (bl[i]) e = e / 2;
            chk(req, cnt[i], e);
        end
    endtask

    function automatic logic [8:0] lmask(int l);
        logic [8:0] m = '0;
        for (int k = 0; k < 3; k++) begin
            int c;
            if (l < 3)       c = 3 * l + k;
            else if (l < 6)  c = (l - 3) + 3 * k;
            else if (l == 6) c = 4 * k;
            else             c = 2 + 2 * k;
            m[c] = 1'b1;
        end
        return m;
    endfunction

    function automatic bit has_line(logic [8:0] m);
        for (int l = 0; l < 8; l++) if ((m & lmask(l)) == lmask(l)) return 1'b1;
        return 1'b0;
    endfunction

    // Plays mv[0..n-1] alternately from player 1, checking turn LEDs (R2).
    task automatic play(int n, output logic [8:0] m1, output logic [8:0] m2);
        m1 = '0;
        m2 = '0;
        for (int k = 0; k < n; k++) begin
            press(9'(1) << mv[k]);
            if (k % 2 == 0) m1[mv[k]] = 1'b1;
            else            m2[mv[k]] = 1'b1;
            if (k < n - 1) begin
                chk("R2 turn", int'(turn_led), (k % 2 == 0) ? 2 : 1);
                chk("R7 no early result", int'(status), 0);
            end
        end
    endtask

    task automatic after_end(string req, int st, logic [8:0] m1, logic [8:0] m2, logic [8:0] bl);
        int free_cell;
        free_cell = 0;
        for (int i = 8; i >= 0; i--) if (!m1[i] && !m2[i]) free_cell = i;
        chk("R11 turn dark", int'(turn_led), 0);
        press(9'h1ff);
        if (!(m1 | m2) != 9'h1ff) press(9'(1) << free_cell);
        chk("R11 status held", int'(status), st);
        check_leds(req, m1, m2, bl);
    endtask

    initial begin
        logic [8:0] m1, m2, lm, others;
        int oc [6];
        int no;

        // R1 reset state
        do_reset();
        chk("R1 status", int'(status), 0);
        chk("R1 turn", int'(turn_led), 1);
        check_leds("R1 leds dark", '0, '0, '0);

        // R6 simultaneous keys on cells 2 and 4: only cell 2 taken by P1
        press(9'b000010100);
        chk("R6 turn", int'(turn_led), 2);
        check_leds("R6 R3 lowest key", 9'b000000100, '0, '0);

        // R4 occupied press by P2 on cell 2
        press(9'b000000100);
        chk("R4 status", int'(status), 1);
        chk("R4 same player", int'(turn_led), 2);
        check_leds("R4 board unchanged", 9'b000000100, '0, '0);

        // R5 valid move clears alarm, P2 dim (R3)
        press(9'b000010000);
        chk("R5 status cleared", int'(status), 0);
        chk("R5 turn", int'(turn_led), 1);
        check_leds("R3 dim p2", 9'b000000100, 9'b000010000, '0);

        // R7 R8 R11: every line won by each player
        for (int p = 0; p < 2; p++) begin
            for (int l = 0; l < 8; l++) begin
                do_reset();
                lm = lmask(l);
                others = ~lm;
                no = 0;
                for (int i = 0; i < 9; i++) if (others[i]) begin oc[no] = i; no++; end
                if (p == 0) begin
                    int li [3];
                    int n3;
                    n3 = 0;
                    for (int i = 0; i < 9; i++) if (lm[i]) begin li[n3] = i; n3++; end
                    mv[0] = li[0]; mv[1] = oc[0]; mv[2] = li[1]; mv[3] = oc[1]; mv[4] = li[2];
                    play(5, m1, m2);
                end else begin
                    int li [3];
                    int n3;
                    int t [3];
                    bit found;
                    n3 = 0;
                    found = 1'b0;
                    for (int i = 0; i < 9; i++) if (lm[i]) begin li[n3] = i; n3++; end
                    for (int a = 0; a < 6; a++)
                        for (int b = a + 1; b < 6; b++)
                            for (int c = b + 1; c < 6; c++)
                                if (!found && !has_line((9'(1) << oc[a]) | (9'(1) << oc[b]) | (9'(1) << oc[c]))) begin
                                    t[0] = oc[a]; t[1] = oc[b]; t[2] = oc[c];
                                    found = 1'b1;
                                end
                    mv[0] = t[0]; mv[1] = li[0]; mv[2] = t[1]; mv[3] = li[1];
                    mv[4] = t[2]; mv[5] = li[2];
                    play(6, m1, m2);
                end
                chk("R7 win status", int'(status), 2 + p);
                check_leds("R8 blink line", m1, m2, lm);
                after_end("R11 keys ignored", 2 + p, m1, m2, lm);
            end
        end

        // R9 draw
        do_reset();
        mv[0] = 0; mv[1] = 1; mv[2] = 2; mv[3] = 4; mv[4] = 3;
        mv[5] = 5; mv[6] = 7; mv[7] = 6; mv[8] = 8;
        play(9, m1, m2);
        chk("R9 draw status", int'(status), 4);
        check_leds("R9 draw leds steady", m1, m2, '0);
        after_end("R11 after draw", 4, m1, m2, '0);

        // R10 ninth move completes diagonal 0-4-8
        do_reset();
        mv[0] = 0; mv[1] = 1; mv[2] = 2; mv[3] = 3; mv[4] = 4;
        mv[5] = 5; mv[6] = 7; mv[7] = 6; mv[8] = 8;
        play(9, m1, m2);
        chk("R10 win over draw", int'(status), 2);
        check_leds("R10 R8 blink diag", m1, m2, 9'b100010001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchecks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
            $finish;
        end
    end

endmodule